// File: doc/BRIEF.md
# Byte-Masked Configuration Register Space

This block holds the configuration register space of a single PCI or PCI Express function. The storage is an array of bytes. Every byte has a write mask that is derived from its offset, so a write can only change the bits the mask allows. A requester issues one access per cycle. Each access is a read or a write of 1, 2 or 4 bytes at any byte offset, and the data is little-endian. The response comes back one cycle later.

A mode input chooses the size of the space for each access. In conventional mode the space is 256 bytes. In express mode it is 4096 bytes. Any access that runs past the end of the selected space is cut short; it does not wrap around to offset zero. The identification bytes are read-only and are loaded from parameters at reset.

Top module: `cfg_byte_space`

## Requirements
- R1: With `extMode` = 0 the space is 256 bytes (offsets 0x000–0x0FF). With `extMode` = 1 it is 4096 bytes (offsets 0x000–0xFFF). Bytes stored above 0x0FF keep their value while conventional mode is selected.
- R2: A written byte becomes (old & ~mask) | (new & mask). Bits whose mask bit is clear keep their old value.
- R3: The write masks are as follows. Offset 0x0C and offset 0x3C have mask 0xFF. Offset 0x04 has mask 0x07 (bit 0 I/O enable, bit 1 memory enable, bit 2 bus master). Every offset from 0x40 up to the end of the space has mask 0xFF. All other offsets below 0x40 have mask 0x00.
- R4: Write byte k (bits 8k+7:8k of `reqWdata`) goes to offset `reqAddr`+k. A byte whose offset is at or beyond the space size is discarded.
- R5: A read returns only the bytes that lie before the end of the space. A read that starts at or beyond the end returns zero.
- R6: Read byte k (from offset `reqAddr`+k) appears in bits 8k+7:8k of `rspRdata`. Bytes that are not fetched read as zero.
- R7: `reqLen` gives the byte count, and only 1, 2 and 4 are legal. Any other value sets `rspErr`, leaves the storage unchanged and returns zero data.
- R8: After reset, offsets 0x00–0x01 hold `VENDOR_ID`, 0x02–0x03 hold `DEVICE_ID`, 0x08 holds `REVISION` and 0x09–0x0B hold `CLASS_CODE`, all little-endian. Every other byte is zero.
- R9: `rspValid` is high in the cycle after each accepted request and low in every other cycle. `rspRdata` and `rspErr` are valid when `rspValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| extMode | input | 1 | 1 selects the 4096-byte space, 0 the 256-byte space |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | 13 | Starting byte offset |
| reqLen | input | 3 | Byte count (1, 2 or 4) |
| reqWdata | input | 32 | Write data, least-significant byte first |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspRdata | output | 32 | Read data, zero-filled |
| rspErr | output | 1 | Illegal length flag |

## Verification
Assertions check several properties on every cycle:
- the one-cycle response timing;
- the error flag on an illegal length, and zero data whenever the flag is set;
- zero data for a read that starts past the end, and a zero top three bytes for a read at the last offset;
- that the identification word never changes and that the command byte never has a bit set above bit 2.

Only the bench's scenarios can show:
- the mask merge on each header byte;
- unaligned accesses that cross a word boundary;
- data written in one mode and read back in the other;
- that illegal writes leave the storage untouched;
- that a second reset restores the parameter values.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int ADDR_W      = 13;
  localparam int OFF_W       = 12;
  localparam int EXT_SIZE    = 4096;
  localparam int LEGACY_SIZE = 256;
  localparam int LANES       = 4;
  localparam int HDR_END     = 64;

  localparam logic [OFF_W-1:0] OFF_CMD     = 12'h004;
  localparam logic [OFF_W-1:0] OFF_LINESZ  = 12'h00C;
  localparam logic [OFF_W-1:0] OFF_IRQLINE = 12'h03C;
  localparam logic [7:0]       CMD_WMASK   = 8'h07;

  typedef struct packed {
    logic             anyReq;
    logic             wrEn;
    logic             rdEn;
    logic             lenErr;
    logic [LANES-1:0] laneEn;
    logic [ADDR_W-1:0] addr;
  } cfg_strobe_t;

  function automatic logic [7:0] wmaskOf(input logic [OFF_W-1:0] off);
    logic [7:0] m;
    if (off >= OFF_W'(HDR_END))  m = 8'hFF;
    else if (off == OFF_LINESZ)  m = 8'hFF;
    else if (off == OFF_IRQLINE) m = 8'hFF;
    else if (off == OFF_CMD)     m = CMD_WMASK;
    else                         m = 8'h00;
    return m;
  endfunction

endpackage

// File: rtl/cfg_space_ctrl.sv
module cfg_space_ctrl
  import cfg_space_pkg::*;
(
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              extMode,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqLen,
  output cfg_strobe_t       strobe
);

  logic              lenOk;
  logic [ADDR_W-1:0] spaceSize;
  logic [ADDR_W-1:0] remaining;
  logic [ADDR_W-1:0] effLen;

  always_comb begin
    lenOk     = (reqLen == 3'd1) || (reqLen == 3'd2) || (reqLen == 3'd4);
    spaceSize = extMode ? ADDR_W'(EXT_SIZE) : ADDR_W'(LEGACY_SIZE);
    remaining = (reqAddr >= spaceSize) ? '0 : (spaceSize - reqAddr);
    effLen    = (ADDR_W'(reqLen) < remaining) ? ADDR_W'(reqLen) : remaining;

    strobe.anyReq = reqValid;
    strobe.wrEn   = reqValid && reqWrite && lenOk;
    strobe.rdEn   = reqValid && !reqWrite && lenOk;
    strobe.lenErr = reqValid && !lenOk;
    strobe.addr   = reqAddr;
    for (int k = 0; k < LANES; k++) begin
      strobe.laneEn[k] = reqValid && lenOk && (ADDR_W'(k) < effLen);
    end
  end

endmodule

// File: rtl/cfg_space_datapath.sv
module cfg_space_datapath
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID  = 16'h7E01,
  parameter logic [7:0]  REVISION   = 8'h11,
  parameter logic [23:0] CLASS_CODE = 24'h0C0330
) (
  input  logic        clk,
  input  logic        rst_n,
  input  cfg_strobe_t strobe,
  input  logic [31:0] wdata,
  output logic        rspValid,
  output logic [31:0] rdata,
  output logic        rspErr
);

  localparam int WORDS  = EXT_SIZE / LANES;
  localparam int WORD_W = $clog2(WORDS);

  logic [31:0] mem [WORDS];

  logic [OFF_W-1:0]  byteOff [LANES];
  logic [WORD_W-1:0] wordIdx [LANES];
  logic [1:0]        laneSel [LANES];
  logic [7:0]        oldByte [LANES];
  logic [7:0]        newByte [LANES];
  logic [31:0]       readWord;

  function automatic logic [31:0] initWord(input int w);
    logic [31:0] v;
    if (w == 0)      v = {DEVICE_ID, VENDOR_ID};
    else if (w == 2) v = {CLASS_CODE, REVISION};
    else             v = '0;
    return v;
  endfunction

  always_comb begin
    readWord = '0;
    for (int k = 0; k < LANES; k++) begin
      byteOff[k] = strobe.addr[OFF_W-1:0] + OFF_W'(k);
      wordIdx[k] = byteOff[k][OFF_W-1:2];
      laneSel[k] = byteOff[k][1:0];
      oldByte[k] = mem[wordIdx[k]][laneSel[k]*8 +: 8];
      newByte[k] = (oldByte[k] & ~wmaskOf(byteOff[k]))
                 | (wdata[k*8 +: 8] & wmaskOf(byteOff[k]));
      if (strobe.rdEn && strobe.laneEn[k]) readWord[k*8 +: 8] = oldByte[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= initWord(w);
    end else if (strobe.wrEn) begin
      for (int k = 0; k < LANES; k++) begin
        if (strobe.laneEn[k]) mem[wordIdx[k]][laneSel[k]*8 +: 8] <= newByte[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rdata    <= '0;
    end else begin
      rspValid <= strobe.anyReq;
      rspErr   <= strobe.lenErr;
      rdata    <= readWord;
    end
  end

  // R8: the identification word has mask zero and must never change
  a_r8_id_word_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mem[0]));

  // R3: command byte bits above bus-master stay clear
  a_r3_cmd_high_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mem[1][7:3] == 5'd0);

endmodule

// File: rtl/cfg_byte_space.sv
module cfg_byte_space
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID  = 16'h7E01,
  parameter logic [7:0]  REVISION   = 8'h11,
  parameter logic [23:0] CLASS_CODE = 24'h0C0330
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        extMode,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [12:0] reqAddr,
  input  logic [2:0]  reqLen,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic [31:0] rspRdata,
  output logic        rspErr
);

  cfg_strobe_t strobe;

  cfg_space_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .extMode  (extMode),
    .reqAddr  (reqAddr),
    .reqLen   (reqLen),
    .strobe   (strobe)
  );

  cfg_space_datapath #(
    .VENDOR_ID  (VENDOR_ID),
    .DEVICE_ID  (DEVICE_ID),
    .REVISION   (REVISION),
    .CLASS_CODE (CLASS_CODE)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .wdata    (reqWdata),
    .rspValid (rspValid),
    .rdata    (rspRdata),
    .rspErr   (rspErr)
  );

  logic legalLen;
  logic [12:0] curSize;
  assign legalLen = (reqLen == 3'd1) || (reqLen == 3'd2) || (reqLen == 3'd4);
  assign curSize  = extMode ? 13'd4096 : 13'd256;

  a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);
  a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);
  a_r7_bad_len_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !legalLen) |=> rspErr);
  a_r7_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rspErr |-> (rspRdata == 32'd0));
  a_r5_past_end_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqWrite && reqAddr >= curSize) |=> (rspRdata == 32'd0));
  a_r5_last_byte_clip: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqWrite && reqAddr == curSize - 13'd1) |=> (rspRdata[31:8] == 24'd0));

endmodule

// File: tb/cfg_byte_space_bench.sv
module cfg_byte_space_bench;

  typedef struct packed {
    logic        ext;
    logic        wr;
    logic [2:0]  len;
    logic [12:0] addr;
    logic [31:0] wdata;
    logic [31:0] expData;
    logic        expErr;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 30;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b0,3'd4,13'h000,32'h0,32'h7E01A5C3,1'b0,4'd8},  // R8 ids
    '{1'b0,1'b0,3'd4,13'h008,32'h0,32'h0C033011,1'b0,4'd8},  // R8 class/rev
    '{1'b0,1'b0,3'd2,13'h001,32'h0,32'h000001A5,1'b0,4'd6},  // R6 unaligned
    '{1'b0,1'b1,3'd4,13'h000,32'hFFFFFFFF,32'h0,1'b0,4'd3},  // R3 ro write
    '{1'b0,1'b0,3'd4,13'h000,32'h0,32'h7E01A5C3,1'b0,4'd3},  // R3 unchanged
    '{1'b0,1'b1,3'd4,13'h004,32'hFFFFFFFF,32'h0,1'b0,4'd3},  // R3 cmd
    '{1'b0,1'b0,3'd4,13'h004,32'h0,32'h00000007,1'b0,4'd3},  // R3 cmd mask
    '{1'b0,1'b1,3'd1,13'h004,32'h000000F8,32'h0,1'b0,4'd2},  // R2 merge
    '{1'b0,1'b0,3'd1,13'h004,32'h0,32'h00000000,1'b0,4'd2},  // R2
    '{1'b0,1'b1,3'd1,13'h004,32'h00000005,32'h0,1'b0,4'd2},  // R2
    '{1'b0,1'b0,3'd1,13'h004,32'h0,32'h00000005,1'b0,4'd2},  // R2
    '{1'b0,1'b1,3'd4,13'h00C,32'h12345678,32'h0,1'b0,4'd3},  // R3 line size
    '{1'b0,1'b0,3'd4,13'h00C,32'h0,32'h00000078,1'b0,4'd3},  // R3
    '{1'b0,1'b1,3'd4,13'h03C,32'hAABBCCDD,32'h0,1'b0,4'd3},  // R3 irq line
    '{1'b0,1'b0,3'd4,13'h03C,32'h0,32'h000000DD,1'b0,4'd3},  // R3
    '{1'b0,1'b1,3'd4,13'h041,32'h44332211,32'h0,1'b0,4'd4},  // R4 crossing
    '{1'b0,1'b0,3'd4,13'h041,32'h0,32'h44332211,1'b0,4'd6},  // R6
    '{1'b0,1'b0,3'd4,13'h040,32'h0,32'h33221100,1'b0,4'd4},  // R4 order
    '{1'b0,1'b1,3'd4,13'h0FE,32'hDDCCBBAA,32'h0,1'b0,4'd4},  // R4 drop tail
    '{1'b0,1'b0,3'd4,13'h0FE,32'h0,32'h0000BBAA,1'b0,4'd5},  // R5 clip
    '{1'b1,1'b0,3'd4,13'h0FE,32'h0,32'h0000BBAA,1'b0,4'd4},  // R4 not written
    '{1'b1,1'b1,3'd4,13'h100,32'h0BADF00D,32'h0,1'b0,4'd1},  // R1 ext write
    '{1'b0,1'b0,3'd1,13'h100,32'h0,32'h00000000,1'b0,4'd1},  // R1 legacy end
    '{1'b1,1'b0,3'd4,13'h100,32'h0,32'h0BADF00D,1'b0,4'd1},  // R1 kept
    '{1'b1,1'b1,3'd4,13'hFFD,32'h87654321,32'h0,1'b0,4'd4},  // R4 ext end
    '{1'b1,1'b0,3'd4,13'hFFC,32'h0,32'h65432100,1'b0,4'd5},  // R5
    '{1'b1,1'b0,3'd4,13'h1000,32'h0,32'h00000000,1'b0,4'd5}, // R5 beyond
    '{1'b1,1'b1,3'd3,13'h100,32'hFFFFFFFF,32'h0,1'b1,4'd7},  // R7 len3 write
    '{1'b1,1'b0,3'd4,13'h100,32'h0,32'h0BADF00D,1'b0,4'd7},  // R7 unchanged
    '{1'b1,1'b0,3'd0,13'h000,32'h0,32'h00000000,1'b1,4'd7}   // R7 len0 read
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        extMode = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [12:0] reqAddr = '0;
  logic [2:0]  reqLen = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspRdata;
  logic        rspErr;

  int checks = 0;
  int errors = 0;
  logic [31:0] gotData;
  logic        gotErr;
  logic        gotValid;

  always #5 clk = ~clk;

  cfg_byte_space #(
    .VENDOR_ID(16'hA5C3), .DEVICE_ID(16'h7E01),
    .REVISION(8'h11), .CLASS_CODE(24'h0C0330)
  ) u_cfg_byte_space (
    .clk(clk), .rst_n(rst_n), .extMode(extMode), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspRdata(rspRdata),
    .rspErr(rspErr)
  );

  task automatic access(input logic ext, input logic wr, input logic [2:0] len,
                        input logic [12:0] addr, input logic [31:0] wd);
    @(negedge clk);
    extMode = ext; reqValid = 1'b1; reqWrite = wr;
    reqLen = len; reqAddr = addr; reqWdata = wd;
    @(negedge clk);
    gotData = rspRdata; gotErr = rspErr; gotValid = rspValid;
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: idle after reset
    @(negedge clk);
    check("R9 reset valid", {31'd0, rspValid}, 32'd0);
    check("R7 reset err", {31'd0, rspErr}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].ext, VECS[i].wr, VECS[i].len, VECS[i].addr, VECS[i].wdata);
      checks++;
      if (gotValid !== 1'b1 || gotErr !== VECS[i].expErr ||
          (!VECS[i].wr && gotData !== VECS[i].expData)) begin
        errors++;
        $display("FAIL vec %0d R%0d actual=%h/%b/%b expected=%h/%b/1", i, VECS[i].req,
                 gotData, gotErr, gotValid, VECS[i].expData, VECS[i].expErr);
      end
    end

    // R9: no response without a request
    @(negedge clk);
    check("R9 idle valid", {31'd0, rspValid}, 32'd0);

    // R7: length 6 read
    access(1'b1, 1'b0, 3'd6, 13'h100, 32'h0);
    check("R7 len6 data", gotData, 32'd0);
    check("R7 len6 err", {31'd0, gotErr}, 32'd1);

    // R8: second reset restores contents
    access(1'b1, 1'b1, 3'd4, 13'h200, 32'hCAFE1234);
    doReset();
    access(1'b1, 1'b0, 3'd4, 13'h200, 32'h0);
    check("R8 cleared after reset", gotData, 32'd0);
    access(1'b1, 1'b0, 3'd4, 13'h004, 32'h0);
    check("R8 cmd cleared", gotData, 32'd0);
    access(1'b1, 1'b0, 3'd4, 13'h000, 32'h0);
    check("R8 ids restored", gotData, 32'h7E01A5C3);

    // R2/R4: two-byte write in the extended area
    access(1'b1, 1'b1, 3'd2, 13'hFFF, 32'h0000BEEF);
    access(1'b1, 1'b0, 3'd1, 13'hFFF, 32'h0);
    check("R4 last byte kept", gotData, 32'h000000EF);
    access(1'b1, 1'b0, 3'd2, 13'h000, 32'h0);
    check("R4 no wrap to zero", gotData, 32'h0000A5C3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule